// File: doc/BRIEF.md
# Triggered Signal Capture Buffer

This block is an on-chip recorder for a bus of probed signals. After an arm strobe it writes one sample of the probe bus per rising edge of its clock into a circular memory. Meanwhile it watches one selected probe bit for a chosen edge. Once the trigger fires, it keeps writing until the post-trigger share of the window is stored, then stops and holds the window for readout. There is no capture on the falling clock edge. The time covered by a window is the depth times the sample-clock period. The default depth of 8192 holds a twelve-bit serial frame at 115200 baud sampled every 20 ns, which needs 5208 samples.

Three fixed ratios set how the window is split around the trigger: a short lead (12% before, 88% after), half and half, and a long lead (88% before, 12% after). The trigger is held off until the whole lead region has been filled after arming. The sample taken in the trigger cycle is the first post-trigger sample. Its address is latched so that the synchronous read port can return the window in time order, with index 0 being the oldest sample.

Top module: `capbuf_top`

## Requirements
- R1: After reset, armed_o, triggered_o and done_o are low and trig_addr_o is 0.
- R2: A high arm_i on a clock edge sets armed_o and clears triggered_o and done_o from the next cycle. It also latches mode_i, trig_sel_i and trig_rise_i. Changes to those inputs while the capture runs have no effect.
- R3: While armed and not done, the probe bus is written once per rising clock edge. The first write after the arm cycle goes to address 0 and the address then advances by one modulo DEPTH. The arm cycle itself writes nothing.
- R4: The trigger looks only at probe bit trig_sel_i. It compares that bit in the current sample against the previous sample: trig_rise_i = 0 selects the 1-to-0 edge and trig_rise_i = 1 selects the 0-to-1 edge. Edges on other bits have no effect.
- R5: A matching edge is ignored while fewer than LEAD samples have been written since arming.
- R6: LEAD is set by mode_i as follows. Code 0 gives floor(DEPTH*12/100). Codes 1 and 3 give DEPTH/2. Code 2 gives DEPTH - floor(DEPTH*12/100). TAIL = DEPTH - LEAD.
- R7: The sample written on the trigger edge is the first post-trigger sample. trig_addr_o takes that sample's address and triggered_o goes high after that edge. trig_addr_o then holds until the next arm.
- R8: On the edge that writes the TAIL-th post-trigger sample, done_o goes high and armed_o goes low. After that, writing stops and later probe values leave the stored window unchanged.
- R9: rd_data_o shows, one cycle after rd_idx_i is presented, the stored sample at address (trig_addr_o - LEAD + rd_idx_i) mod DEPTH. Index 0 is therefore the oldest sample of the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, rising edge only |
| rst_i | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Arm strobe; restarts a capture |
| probe_i | input | PROBE_W | Probed signal bus |
| mode_i | input | 2 | Window split code |
| trig_sel_i | input | SEL_W | Index of the trigger bit |
| trig_rise_i | input | 1 | 1: rising edge, 0: falling edge |
| rd_idx_i | input | AW | Read index, 0 = oldest sample |
| armed_o | output | 1 | Capture running |
| triggered_o | output | 1 | Trigger seen in this capture |
| done_o | output | 1 | Window complete and frozen |
| trig_addr_o | output | AW | Address of the trigger sample |
| rd_data_o | output | PROBE_W | Read data, one cycle latency |

## Verification
The bench builds the block with PROBE_W = 8 and DEPTH = 64. With these values the lead lengths are 7, 32 and 57 samples, so every split mode runs to completion, and the circular address wraps, within a few hundred cycles. The short window also lets every readout compare all 64 entries against the probe history. It puts the trigger exactly on the lead boundary and puts a decoy edge one sample before it.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;

   typedef enum logic [1:0] {
      MODE_SHORT_LEAD = 2'd0,
      MODE_HALF       = 2'd1,
      MODE_LONG_LEAD  = 2'd2,
      MODE_HALF_ALT   = 2'd3
   } win_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FILL = 2'd1,
      ST_POST = 2'd2,
      ST_DONE = 2'd3
   } cap_state_e;

   // Number of samples kept ahead of the trigger for a given split code.
   function automatic int unsigned lead_count(int unsigned depth, win_mode_e m);
      int unsigned short_lead;
      short_lead = (depth * 12) / 100;
      case (m)
         MODE_SHORT_LEAD: return short_lead;
         MODE_LONG_LEAD:  return depth - short_lead;
         default:         return depth / 2;
      endcase
   endfunction

endpackage

// File: rtl/capbuf_trig.sv
module capbuf_trig
   import capbuf_pkg::*;
#(
   parameter int PROBE_W = 8,
   parameter int SEL_W   = 3
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic [PROBE_W-1:0] probe_i,
   input  logic [SEL_W-1:0]   sel_i,
   input  logic               rise_i,
   input  logic               qual_i,
   output logic               hit_o
);

   logic cur_bit;
   logic prev_bit_q;

   generate
      if (PROBE_W == 1) begin : g_single
         logic unused_sel;
         assign unused_sel = ^sel_i;
         assign cur_bit    = probe_i[0];
      end else begin : g_mux
         always_comb begin
            cur_bit = 1'b0;
            for (int k = 0; k < PROBE_W; k++) begin
               if (int'(sel_i) == k) cur_bit = probe_i[k];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) prev_bit_q <= 1'b0;
      else       prev_bit_q <= cur_bit;
   end

   always_comb begin
      if (rise_i) hit_o = qual_i & ~prev_bit_q &  cur_bit;
      else        hit_o = qual_i &  prev_bit_q & ~cur_bit;
   end

endmodule

// File: rtl/capbuf_seq.sv
module capbuf_seq
   import capbuf_pkg::*;
#(
   parameter int DEPTH = 8192,
   parameter int SEL_W = 3,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             arm_i,
   input  logic [1:0]       mode_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             rise_i,
   input  logic             hit_i,
   output logic             qual_o,
   output logic             wr_en_o,
   output logic [AW-1:0]    wr_addr_o,
   output logic [SEL_W-1:0] sel_o,
   output logic             rise_o,
   output logic [AW-1:0]    lead_o,
   output logic [AW-1:0]    trig_addr_o,
   output logic             armed_o,
   output logic             trig_o,
   output logic             done_o
);

   localparam logic [CW-1:0] LEAD_SHORT = CW'(lead_count(DEPTH, MODE_SHORT_LEAD));
   localparam logic [CW-1:0] LEAD_HALF  = CW'(lead_count(DEPTH, MODE_HALF));
   localparam logic [CW-1:0] LEAD_LONG  = CW'(lead_count(DEPTH, MODE_LONG_LEAD));
   localparam logic [CW-1:0] FULL       = CW'(DEPTH);

   cap_state_e       state_q;
   win_mode_e        mode_q;
   logic [AW-1:0]    wr_addr_q;
   logic [CW-1:0]    seen_q;
   logic [CW-1:0]    post_q;
   logic [AW-1:0]    trig_addr_q;
   logic [SEL_W-1:0] sel_q;
   logic             rise_q;
   logic [CW-1:0]    lead_len;
   logic [CW-1:0]    tail_len;

   always_comb begin
      case (mode_q)
         MODE_SHORT_LEAD: lead_len = LEAD_SHORT;
         MODE_LONG_LEAD:  lead_len = LEAD_LONG;
         default:         lead_len = LEAD_HALF;
      endcase
      tail_len = FULL - lead_len;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q     <= ST_IDLE;
         mode_q      <= MODE_SHORT_LEAD;
         wr_addr_q   <= '0;
         seen_q      <= '0;
         post_q      <= '0;
         trig_addr_q <= '0;
         sel_q       <= '0;
         rise_q      <= 1'b0;
      end else if (arm_i) begin
         state_q   <= ST_FILL;
         mode_q    <= win_mode_e'(mode_i);
         wr_addr_q <= '0;
         seen_q    <= '0;
         post_q    <= '0;
         sel_q     <= sel_i;
         rise_q    <= rise_i;
      end else begin
         case (state_q)
            ST_FILL: begin
               wr_addr_q <= wr_addr_q + AW'(1);
               if (seen_q < lead_len) seen_q <= seen_q + CW'(1);
               if (hit_i) begin
                  trig_addr_q <= wr_addr_q;
                  post_q      <= CW'(1);
                  state_q     <= (tail_len == CW'(1)) ? ST_DONE : ST_POST;
               end
            end
            ST_POST: begin
               wr_addr_q <= wr_addr_q + AW'(1);
               post_q    <= post_q + CW'(1);
               if (post_q == tail_len - CW'(1)) state_q <= ST_DONE;
            end
            default: ;
         endcase
      end
   end

   assign qual_o      = (state_q == ST_FILL) && (seen_q >= lead_len);
   assign wr_en_o     = !arm_i && ((state_q == ST_FILL) || (state_q == ST_POST));
   assign wr_addr_o   = wr_addr_q;
   assign sel_o       = sel_q;
   assign rise_o      = rise_q;
   assign lead_o      = lead_len[AW-1:0];
   assign trig_addr_o = trig_addr_q;
   assign armed_o     = (state_q == ST_FILL) || (state_q == ST_POST);
   assign trig_o      = (state_q == ST_POST) || (state_q == ST_DONE);
   assign done_o      = (state_q == ST_DONE);

endmodule

// File: rtl/capbuf_store.sv
module capbuf_store #(
   parameter int W     = 8,
   parameter int DEPTH = 8192,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk_i,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [W-1:0]  wdata_i,
   input  logic [AW-1:0] raddr_i,
   output logic [W-1:0]  rdata_o
);

   logic [W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk_i) begin
      if (we_i) mem_q[waddr_i] <= wdata_i;
   end

   always_ff @(posedge clk_i) begin
      rdata_o <= mem_q[raddr_i];
   end

endmodule

// File: rtl/capbuf_top.sv
module capbuf_top
   import capbuf_pkg::*;
#(
   parameter int PROBE_W = 8,
   parameter int DEPTH   = 8192,
   localparam int AW     = $clog2(DEPTH),
   localparam int SEL_W  = (PROBE_W > 1) ? $clog2(PROBE_W) : 1
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               arm_i,
   input  logic [PROBE_W-1:0] probe_i,
   input  logic [1:0]         mode_i,
   input  logic [SEL_W-1:0]   trig_sel_i,
   input  logic               trig_rise_i,
   input  logic [AW-1:0]      rd_idx_i,
   output logic               armed_o,
   output logic               triggered_o,
   output logic               done_o,
   output logic [AW-1:0]      trig_addr_o,
   output logic [PROBE_W-1:0] rd_data_o
);

   initial begin
      assert (DEPTH >= 16 && (1 << AW) == DEPTH)
         else $fatal(1, "capbuf_top: DEPTH must be a power of two of at least 16");
      assert (PROBE_W >= 1)
         else $fatal(1, "capbuf_top: PROBE_W must be at least 1");
   end

   logic             qual;
   logic             hit;
   logic             wr_en;
   logic [AW-1:0]    wr_addr;
   logic [SEL_W-1:0] sel_q;
   logic             rise_q;
   logic [AW-1:0]    lead;
   logic [AW-1:0]    rd_addr;

   capbuf_seq #(
      .DEPTH (DEPTH),
      .SEL_W (SEL_W)
   ) u_seq (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .arm_i       (arm_i),
      .mode_i      (mode_i),
      .sel_i       (trig_sel_i),
      .rise_i      (trig_rise_i),
      .hit_i       (hit),
      .qual_o      (qual),
      .wr_en_o     (wr_en),
      .wr_addr_o   (wr_addr),
      .sel_o       (sel_q),
      .rise_o      (rise_q),
      .lead_o      (lead),
      .trig_addr_o (trig_addr_o),
      .armed_o     (armed_o),
      .trig_o      (triggered_o),
      .done_o      (done_o)
   );

   capbuf_trig #(
      .PROBE_W (PROBE_W),
      .SEL_W   (SEL_W)
   ) u_trig (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .probe_i (probe_i),
      .sel_i   (sel_q),
      .rise_i  (rise_q),
      .qual_i  (qual),
      .hit_o   (hit)
   );

   // Rebase the read index onto the oldest address of the frozen window.
   assign rd_addr = trig_addr_o - lead + rd_idx_i;

   capbuf_store #(
      .W     (PROBE_W),
      .DEPTH (DEPTH)
   ) u_store (
      .clk_i   (clk_i),
      .we_i    (wr_en),
      .waddr_i (wr_addr),
      .wdata_i (probe_i),
      .raddr_i (rd_addr),
      .rdata_o (rd_data_o)
   );

endmodule

// File: rtl/capbuf_chk.sv
module capbuf_chk #(
   parameter int AW = 13
) (
   input logic          clk_i,
   input logic          rst_i,
   input logic          arm_i,
   input logic          armed_o,
   input logic          triggered_o,
   input logic          done_o,
   input logic [AW-1:0] trig_addr_o
);

   assert_reset_idle_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(rst_i) |-> (!armed_o && !triggered_o && !done_o));

   assert_arm_clears_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      arm_i |=> (armed_o && !triggered_o && !done_o));

   assert_done_needs_trigger_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(done_o) |-> triggered_o);

   assert_trig_addr_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (triggered_o && $past(triggered_o) && !$past(arm_i)) |-> $stable(trig_addr_o));

   assert_done_not_armed_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |-> !armed_o);

   assert_done_holds_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      (done_o && !arm_i) |=> done_o);

   assert_armed_exit_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      (armed_o && !arm_i) |=> (armed_o || done_o));

endmodule

bind capbuf_top capbuf_chk #(.AW(AW)) u_chk (
   .clk_i       (clk_i),
   .rst_i       (rst_i),
   .arm_i       (arm_i),
   .armed_o     (armed_o),
   .triggered_o (triggered_o),
   .done_o      (done_o),
   .trig_addr_o (trig_addr_o)
);

// File: tb/sim_capbuf_top.sv
module sim_capbuf_top;

   localparam int CLK_PERIOD = 10;
   localparam int PW    = 8;
   localparam int DEPTH = 64;
   localparam int AW    = 6;
   localparam int SW    = 3;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          arm = 1'b0;
   logic [PW-1:0] probe = '0;
   logic [1:0]    mode = 2'd0;
   logic [SW-1:0] tsel = '0;
   logic          trise = 1'b0;
   logic [AW-1:0] rd_idx = '0;
   logic          armed, trig, done;
   logic [AW-1:0] taddr;
   logic [PW-1:0] rd_data;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;
   logic [PW-1:0] hist [0:255];

   always #(CLK_PERIOD/2) clk = ~clk;

   capbuf_top #(.PROBE_W(PW), .DEPTH(DEPTH)) u0 (
      .clk_i(clk), .rst_i(rst), .arm_i(arm), .probe_i(probe), .mode_i(mode),
      .trig_sel_i(tsel), .trig_rise_i(trise), .rd_idx_i(rd_idx),
      .armed_o(armed), .triggered_o(trig), .done_o(done),
      .trig_addr_o(taddr), .rd_data_o(rd_data));

   function automatic int lead_of(int m);
      int s;
      s = DEPTH * 12 / 100;
      if (m == 0) return s;
      if (m == 2) return DEPTH - s;
      return DEPTH / 2;
   endfunction

   task automatic check(string tag, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   // One full capture: decoy edge at index e (before lead is filled), trigger at t.
   task automatic run(int m, bit rise, int sel, int e, int t);
      int lead, tail, last;
      bit idle;
      lead = lead_of(m);
      tail = DEPTH - lead;
      last = t + tail - 1;
      idle = rise ? 1'b0 : 1'b1;
      for (int i = 0; i <= last + 5; i++) begin
         hist[i] = PW'($urandom);
         if (i < t) hist[i][sel] = (i == e) ? ~idle : idle;
         else if (i == t) hist[i][sel] = ~idle;
      end
      @(negedge clk);
      arm = 1'b1; mode = 2'(m); tsel = SW'(sel); trise = rise;
      @(negedge clk);
      arm = 1'b0;
      check("R2 armed after arm", int'(armed), 1);
      check("R2 triggered cleared", int'(trig), 0);
      check("R2 done cleared", int'(done), 0);
      // R2: configuration changes after the arm must not matter
      mode = 2'($urandom); tsel = SW'($urandom); trise = ~rise;
      for (int i = 0; i <= last + 5; i++) begin
         probe = hist[i];
         @(negedge clk);
         if (i == e) check("R5 early edge ignored", int'(trig), 0);
         if (i == t - 1) check("R4 no trigger before edge", int'(trig), 0);
         if (i == t) begin
            check("R7 triggered after trigger edge", int'(trig), 1);
            check("R7 trigger address", int'(taddr), t % DEPTH);
         end
         if (i == last - 1 && tail >= 2) check("R8 done not early", int'(done), 0);
         if (i == last) begin
            check("R8 done at tail end", int'(done), 1);
            check("R8 armed dropped", int'(armed), 0);
         end
      end
      check("R8 done held after extra samples", int'(done), 1);
      for (int j = 0; j < DEPTH; j++) begin
         rd_idx = AW'(j);
         @(negedge clk);
         // R9 oldest-first readout; R3 one write per edge; R8 no writes after done
         check($sformatf("R9 window[%0d]", j), int'(rd_data), int'(hist[t - lead + j]));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R1 armed reset", int'(armed), 0);
      check("R1 triggered reset", int'(trig), 0);
      check("R1 done reset", int'(done), 0);
      check("R1 trig addr reset", int'(taddr), 0);
      // R6 short lead, trigger exactly at the lead boundary
      run(0, 1'b0, 0, 2, 7);
      // R5 decoy edge one sample before the lead is filled
      run(0, 1'b0, 3, 6, 9);
      // R6 long lead, rising edge, wrap of circular address
      run(2, 1'b1, 7, 2, 70);
      // R6 half split
      run(1, 1'b0, 5, 2, 40);
      // R6 code 3 behaves as half split
      run(3, 1'b1, 1, 2, 33);
      // R2 abandoned capture then re-arm
      @(negedge clk); arm = 1'b1; mode = 2'd1;
      @(negedge clk); arm = 1'b0;
      repeat (10) begin probe = PW'($urandom); @(negedge clk); end
      for (int k = 0; k < 6; k++) begin
         int m;
         m = int'($urandom % 4);
         run(m, 1'($urandom), int'($urandom % PW), 2, lead_of(m) + int'($urandom % 20));
      end
      finish_run();
   end

endmodule